// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Channel

This block is one channel of a pulse-width timer. A clock prescaler and a power-of-two divider turn the system clock into a slower count tick. A down counter steps once per tick. Software writes the period value and the compare value into buffer registers, and these buffers reach the live counter and the live compare register only in two ways. One is a manual-update control bit, which software sets and then clears again. The other is an automatic reload, which happens each time the counter runs out while auto-reload is on.

The output level is evaluated only after a decrement. It goes high once the counter has stepped down to or below the compare value. It is optionally inverted on its way to the pin. A one-clock expiry pulse marks each time the counter reaches zero. A run bit starts or freezes the channel. Software reaches every setting through a small write/read register port. The same port also reads back the live counter and the live compare value.

Top module: `pwm_down_timer`

Register map (address on `wr_addr`/`rd_addr`):
- 0 control: bit 0 run, bit 1 manual update, bit 2 auto-reload, bit 3 invert.
- 1 clock setup: bits 7:0 prescale value P, bits 11:8 divider select.
- 2 period buffer.
- 3 compare buffer.
- 4 live counter, read only.
- 5 live compare, read only.

## Requirements
- R1: The count tick has a period of T = (P+1)*D clocks, where P is the 8-bit prescale value and D is the divider ratio. With auto-reload on and a period buffer value N of at least 1, the expiry pulses come every (N+1)*T clocks.
- R2: The divider select field maps 0 to D=2, 1 to D=4 and 2 to D=8. Every value from 3 to 15 gives D=16. Two ticks never fall on adjacent clocks.
- R3: A write to the period or compare buffer leaves the live counter unchanged until an update or a reload occurs. The buffer reads back the written value at once.
- R4: While the manual-update bit is 1, the live registers are loaded from the buffers each clock and the output level is forced low. If the channel is also stopped, the prescale and divide phase is cleared. After that, the first decrement follows exactly T clocks after run is set.
- R5: On each tick the counter steps down by one. Only after a decrement does the output level become high or low, and it is high when the new count is at or below the live compare value. Over one auto-reload period the output is high for min(C+2, N+1)*T clocks, where C is the compare value.
- R6: A compare value equal to or above N-1 keeps the output from ever going low after the first decrement.
- R7: With auto-reload on, a tick seen at count 0 reloads the counter and the compare from the buffers. This reload does not change the output level.
- R8: With auto-reload off, the counter stays at 0 once it gets there, and only one expiry pulse is produced.
- R9: While both run and manual update are 0, the counter and the output pin hold their values.
- R10: With the inverter fitted (HAS_INVERTER=1), control bit 3 inverts the pin.
- R11: With HAS_INVERTER=0, control bit 3 reads back as 0 and has no effect on the pin.
- R12: The expiry pulse is high for exactly one clock, namely the clock in which the counter holds 0 after a decrement.
- R13: After reset every register, the live counter, the pin and the expiry pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | ADDR_W | write address |
| wr_data | input | DATA_W | write data |
| rd_addr | input | ADDR_W | read address |
| rd_data | output | DATA_W | read data, combinational |
| pwm_out | output | 1 | PWM pin level |
| expire | output | 1 | one-clock pulse when the count reaches 0 |

## Verification
The assertions assume the following about the inputs:
- Software never changes the prescale value while the channel runs, so the prescale phase always moves forward toward its wrap point.
- The manual-update bit is treated as a level, and it is cleared before the channel is started.

The bench keeps within these assumptions. It always writes the control register with update set and run clear before it writes the clock setup or the buffers. It then writes run with update clear as a separate step. The sweep only uses buffer values that fit the 16-bit counter.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   typedef struct packed {
      logic inv;
      logic arl;
      logic upd;
      logic run;
   } ctrl_t;

   // last divider phase for a select code: ratios 2,4,8 then 16
   function automatic logic [3:0] div_last(input logic [3:0] sel);
      case (sel)
         4'd0:    div_last = 4'd1;
         4'd1:    div_last = 4'd3;
         4'd2:    div_last = 4'd7;
         default: div_last = 4'd15;
      endcase
   endfunction

endpackage

// File: rtl/pwm_clk_divider.sv
module pwm_clk_divider #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             phase_clr,
   input  logic [PRE_W-1:0] presc,
   input  logic [3:0]       div_sel,
   output logic             tick
);
   import pwm_timer_pkg::*;

   logic [PRE_W-1:0] pre_q;
   logic [3:0]       div_q;
   logic [3:0]       lim;
   logic             pre_wrap;
   logic             div_wrap;

   assign lim      = div_last(div_sel);
   assign pre_wrap = (pre_q >= presc);
   assign div_wrap = (div_q >= lim);
   assign tick     = run && pre_wrap && div_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         div_q <= '0;
      end else if (phase_clr) begin
         pre_q <= '0;
         div_q <= '0;
      end else if (run) begin
         if (pre_wrap) begin
            pre_q <= '0;
            div_q <= div_wrap ? 4'd0 : div_q + 4'd1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   // R2
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R4
   phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_clr |=> !tick);

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             auto_reload,
   input  logic [CNT_W-1:0] cnt_buf,
   input  logic [CNT_W-1:0] cmp_buf,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmp_live,
   output logic             level,
   output logic             expire
);
   logic [CNT_W-1:0] dec;
   logic             at_zero;

   assign dec     = cnt - CNT_W'(1);
   assign at_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         cmp_live <= '0;
         level    <= 1'b0;
         expire   <= 1'b0;
      end else if (load) begin
         cnt      <= cnt_buf;
         cmp_live <= cmp_buf;
         level    <= 1'b0;
         expire   <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (tick) begin
            if (!at_zero) begin
               cnt    <= dec;
               level  <= (dec <= cmp_live);
               expire <= (dec == '0);
            end else if (auto_reload) begin
               cnt      <= cnt_buf;
               cmp_live <= cmp_buf;
            end
         end
      end
   end

   // R5
   decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

   // R12
   expire_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   // R8
   oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt == '0 && !auto_reload) |=> (cnt == '0));

   // R7
   reload_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt == '0) |=> $stable(level));

   // R4
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(cnt_buf) && !level));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
   parameter bit HAS_INVERTER = 1'b1
) (
   input  logic level,
   input  logic inv,
   output logic pin
);
   generate
      if (HAS_INVERTER) begin : g_inv
         assign pin = level ^ inv;
      end else begin : g_plain
         logic unused_inv;
         assign unused_inv = inv;
         assign pin = level;
      end
   endgenerate
endmodule

// File: rtl/pwm_down_timer.sv
module pwm_down_timer #(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 3,
   parameter int CNT_W        = 16,
   parameter int PRE_W        = 8,
   parameter bit HAS_INVERTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              pwm_out,
   output logic              expire
);
   import pwm_timer_pkg::*;

   localparam int CFG_W = PRE_W + 4;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CNTB = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_CMPB = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(5);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (PRE_W < 1 || CFG_W > DATA_W) begin : g_bad_pre
         $error("PRE_W plus the 4-bit divider select must fit DATA_W");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [PRE_W-1:0] presc_q;
   logic [3:0]       dsel_q;
   logic [CNT_W-1:0] cntb_q;
   logic [CNT_W-1:0] cmpb_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cmp_live;
   logic             level;
   logic             tick;
   logic             counting;
   logic             phase_clr;
   logic             unused_wr;

   assign unused_wr = &{1'b0, wr_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         presc_q <= '0;
         dsel_q  <= '0;
         cntb_q  <= '0;
         cmpb_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL: begin
               ctrl_q.run <= wr_data[0];
               ctrl_q.upd <= wr_data[1];
               ctrl_q.arl <= wr_data[2];
               ctrl_q.inv <= HAS_INVERTER ? wr_data[3] : 1'b0;
            end
            A_CFG: begin
               presc_q <= wr_data[PRE_W-1:0];
               dsel_q  <= wr_data[PRE_W +: 4];
            end
            A_CNTB:  cntb_q <= wr_data[CNT_W-1:0];
            A_CMPB:  cmpb_q <= wr_data[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = DATA_W'(ctrl_q);
         A_CFG:   rd_data = DATA_W'({dsel_q, presc_q});
         A_CNTB:  rd_data = DATA_W'(cntb_q);
         A_CMPB:  rd_data = DATA_W'(cmpb_q);
         A_CNT:   rd_data = DATA_W'(cnt);
         A_CMP:   rd_data = DATA_W'(cmp_live);
         default: rd_data = '0;
      endcase
   end

   assign counting  = ctrl_q.run && !ctrl_q.upd;
   assign phase_clr = ctrl_q.upd && !ctrl_q.run;

   pwm_clk_divider #(.PRE_W(PRE_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (counting),
      .phase_clr (phase_clr),
      .presc     (presc_q),
      .div_sel   (dsel_q),
      .tick      (tick)
   );

   pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .load        (ctrl_q.upd),
      .auto_reload (ctrl_q.arl),
      .cnt_buf     (cntb_q),
      .cmp_buf     (cmpb_q),
      .cnt         (cnt),
      .cmp_live    (cmp_live),
      .level       (level),
      .expire      (expire)
   );

   pwm_out_stage #(.HAS_INVERTER(HAS_INVERTER)) u_out (
      .level (level),
      .inv   (ctrl_q.inv),
      .pin   (pwm_out)
   );

   // R9
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !ctrl_q.upd && !(wr_en && wr_addr == A_CTRL))
         |=> ($stable(cnt) && $stable(level)));

   // R11
   no_inverter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_INVERTER |-> (pwm_out == level && !ctrl_q.inv));

endmodule

// File: tb/pwm_down_timer_bench.sv
module pwm_down_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data, rd_data_ti;
   logic        pwm_out, pwm_out_ti, expire, expire_ti;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pwm_down_timer u_pwm_down_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pwm_out(pwm_out), .expire(expire));

   pwm_down_timer #(.HAS_INVERTER(1'b0)) u_pwm_down_timer_ti (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_ti),
      .pwm_out(pwm_out_ti), .expire(expire_ti));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int ratio(input int sel);
      return (sel >= 3) ? 16 : (2 << sel);
   endfunction

   // one auto-reload period measured between two expiry pulses
   task automatic measure(input int p, input int sel, input int n, input int c, input int inv);
      int t, period, hi, hi_ti, raw, exp_hi;
      t = (p + 1) * ratio(sel);
      wr(0, 2);
      wr(1, (sel << 8) | p);
      wr(2, n);
      wr(3, c);
      wr(0, 1 | 4 | (inv << 3));
      while (!expire) @(negedge clk);
      period = 0; hi = 0; hi_ti = 0;
      do begin
         if (pwm_out) hi++;
         if (pwm_out_ti) hi_ti++;
         period++;
         @(negedge clk);
         if (period == 1)
            chk(!expire, "R12 pulse one clock", int'(expire), 0);
      end while (!expire);
      raw = ((c + 2) < (n + 1) ? (c + 2) : (n + 1)) * t;
      exp_hi = inv ? (n + 1) * t - raw : raw;
      // R1 R2 R7: period from prescale, divider ratio and reload
      chk(period == (n + 1) * t, "R1 R2 R7 period", period, (n + 1) * t);
      // R5 R6 R10: high time with optional inversion
      chk(hi == exp_hi, "R5 R6 R10 high time", hi, exp_hi);
      // R11: no-inverter channel ignores bit 3
      chk(hi_ti == raw, "R11 plain high time", hi_ti, raw);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int held, pulses;
      logic pin_held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 reset state
      for (int a = 0; a < 6; a++) begin
         rd_addr = 3'(a);
         #0;
         chk(rd_data == 0, "R13 reset register", int'(rd_data), 0);
      end
      chk(!pwm_out && !expire, "R13 reset pins", int'({pwm_out, expire}), 0);

      // R4: phase clear and first decrement after T clocks (P=2, D=4, T=12)
      wr(0, 2);
      wr(1, (1 << 8) | 2);
      wr(2, 5);
      wr(3, 1);
      wr(0, 1);
      repeat (7) @(negedge clk);
      wr(0, 0);
      wr(0, 2);
      wr(0, 1);
      rd_addr = 3'd4;
      repeat (11) @(negedge clk);
      chk(rd_data == 5, "R4 count before first tick", int'(rd_data), 5);
      @(negedge clk);
      chk(rd_data == 4, "R4 R5 first decrement", int'(rd_data), 4);

      // R9: halt holds counter and pin
      repeat (20) @(negedge clk);
      wr(0, 0);
      held = int'(rd_data);
      pin_held = pwm_out;
      repeat (50) @(negedge clk);
      chk(int'(rd_data) == held, "R9 counter held", int'(rd_data), held);
      chk(pwm_out == pin_held, "R9 pin held", int'(pwm_out), int'(pin_held));

      // R3: buffer write does not reach live counter
      wr(2, 9);
      chk(int'(rd_data) == held, "R3 live counter unchanged", int'(rd_data), held);
      rd_addr = 3'd2;
      #0;
      chk(rd_data == 9, "R3 buffer readback", int'(rd_data), 9);
      rd_addr = 3'd4;
      wr(0, 2);
      @(negedge clk);
      chk(rd_data == 9, "R4 update loads counter", int'(rd_data), 9);

      // R11: inverter bit absent on the plain channel
      wr(0, 8);
      rd_addr = 3'd0;
      #0;
      chk(rd_data_ti[3] == 1'b0, "R11 invert bit reads 0", int'(rd_data_ti[3]), 0);
      chk(rd_data[3] == 1'b1, "R10 invert bit stored", int'(rd_data[3]), 1);
      chk(pwm_out != pwm_out_ti, "R10 R11 pins differ", int'(pwm_out), int'(!pwm_out_ti));

      // R8: one-shot stops at zero with one pulse (P=0, D=2)
      wr(0, 2);
      wr(1, 0);
      wr(2, 3);
      wr(0, 1);
      pulses = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (expire) pulses++;
      end
      rd_addr = 3'd4;
      #0;
      chk(rd_data == 0, "R8 stopped at zero", int'(rd_data), 0);
      chk(pulses == 1, "R8 single pulse", pulses, 1);

      // R1 R2 R5 R6 R7 R10 R11 R12 sweep
      for (int pi = 0; pi < 3; pi++) begin
         for (int si = 0; si < 5; si++) begin
            for (int k = 0; k < 4; k++) begin
               int p, sel, n, c;
               p   = (pi == 2) ? 3 : pi;
               sel = (si == 4) ? 7 : si;
               n   = (k == 3) ? 2 : 3;
               c   = (k == 3) ? 5 : ((k == 2) ? 3 : k);
               measure(p, sel, n, c, (pi + si + k) & 1);
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule